// File: doc/BRIEF.md
# Flash Sector SEC-DED ECC Engine

This block sits on the data path between a sector buffer and a flash array model. It protects each sector with two independent single-error-correcting, double-error-detecting codes. A wide code covers the whole main area. A narrow code covers only two words of the spare area. A sector enters as a contiguous stream of words, marked by start and end flags. The engine stores the sector internally and accumulates check bits while the words arrive. After the last word it evaluates the result in one cycle and then plays the sector back, one word per cycle.

On a program pass, the engine issues the freshly computed codes so that they can be written to the array. On a load pass, the host supplies the codes that were stored at program time. The engine forms a syndrome for each region and reports one of three outcomes together with the failing bit position. It flips the failing bit in the playback stream. The codes it issues on a load are the stored ones, unchanged.

A bypass input turns the engine into a plain store-and-forward path. In bypass, no code is issued on a program pass, no correction is applied on a load pass, and both status fields read as invalid.

Top module: `fecc_engine`

## Requirements
- R1: On a program pass with bypass low, `ecc_valid_o` pulses for one cycle after the end-of-sector word. `ecc_main_o` and `ecc_spare_o` carry the computed codes. For a region with address width A, code bit 2k+1 is the XOR of every data bit whose bit index has bit k set, and code bit 2k is the XOR of every data bit whose bit index has bit k clear. The main bit index is word*16+bit over words 0..255 (A=12, 24 bits). The spare bit index is (word-257)*16+bit over sector words 257 and 258 (A=5, 10 bits).
- R2: After each sector, the engine plays back all 264 words in arrival order, in contiguous cycles. `out_sop_o` marks the first word and `out_eop_o` marks the last.
- R3: Status encoding is 00 for no error, 01 for correctable, 10 for uncorrectable and 11 for invalid. A load with matching codes reports 00 in both regions, position 0, and plays the data back unchanged.
- R4: A load with one flipped main data bit reports main status 01 with `main_pos_o` equal to that bit index, and plays the bit back corrected. This holds at indexes 0 and 4095.
- R5: A load whose main syndrome has exactly one bit set (a check-bit error) reports status 01 with position 0 and leaves the data unchanged.
- R6: A load with two flipped main data bits reports main status 10 and plays the data back as received.
- R7: Spare words 257 and 258 are protected by the 10-bit code, with single-bit correction and its position reported on `spare_pos_o`. A flip in any other spare word leaves the spare status at 00 and is played back as received.
- R8: On a load, `ecc_valid_o` pulses with the stored codes that were presented with the sector, never the recomputed ones.
- R9: On a program pass with bypass high, `ecc_valid_o` does not pulse.
- R10: On a load with bypass high, both statuses read 11, both positions read 0, no bit is corrected, and the stored codes are still returned.
- R11: After reset, `busy_o`, `out_valid_o` and `ecc_valid_o` are low and both statuses are 00. `busy_o` stays high from the first accepted word until the last playback word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_bypass_i | input | 1 | Bypass mode: no generation, correction or valid status |
| op_load_i | input | 1 | 1 = load pass, 0 = program pass; sampled with the end word |
| in_valid_i | input | 1 | Input word valid |
| in_sop_i | input | 1 | First word of a sector |
| in_eop_i | input | 1 | Last word of a sector |
| in_data_i | input | 16 | Input data word |
| stored_main_ecc_i | input | 24 | Program-time main code, sampled with the end word |
| stored_spare_ecc_i | input | 10 | Program-time spare code, sampled with the end word |
| busy_o | output | 1 | Sector in progress |
| out_valid_o | output | 1 | Playback word valid |
| out_sop_o | output | 1 | First playback word |
| out_eop_o | output | 1 | Last playback word |
| out_data_o | output | 16 | Playback word, corrected where applicable |
| ecc_valid_o | output | 1 | Code outputs valid (one-cycle pulse) |
| ecc_main_o | output | 24 | Main code: computed on program, stored on load |
| ecc_spare_o | output | 10 | Spare code: computed on program, stored on load |
| result_valid_o | output | 1 | Load result updated (one-cycle pulse) |
| main_status_o | output | 2 | Main region outcome |
| main_pos_o | output | 12 | Main failing bit index |
| spare_status_o | output | 2 | Spare region outcome |
| spare_pos_o | output | 5 | Spare failing bit index |

## Verification
The check-bit error case is the hardest to reach from the ports. It needs a syndrome with exactly one bit set, and no flip of data bits can produce that. The stimulus therefore computes clean codes in the bench, sends clean data, and flips a single bit of the stored code that is presented with the end word. The position corners at bit indexes 0 and 4095 and the unprotected spare words are reached the same way: one chosen bit is flipped in an otherwise clean sector.

// File: rtl/fecc_pkg.sv
package fecc_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN   = 2'b00,
    ST_FIXED   = 2'b01,
    ST_FATAL   = 2'b10,
    ST_INVALID = 2'b11
  } ecc_status_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RECV = 2'd1,
    PH_EVAL = 2'd2,
    PH_SEND = 2'd3
  } phase_e;
endpackage

// File: rtl/fecc_accum.sv
// Running check-bit accumulator for one protected region.
module fecc_accum #(
  parameter int DATA_W = 16,
  parameter int AW     = 12
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             clear_i,
  input  logic                             en_i,
  input  logic [AW-$clog2(DATA_W)-1:0]     widx_i,
  input  logic [DATA_W-1:0]                data_i,
  output logic [2*AW-1:0]                  code_o
);
  localparam int LW = $clog2(DATA_W);
  localparam int WI = AW - LW;
  localparam int EW = 2 * AW;

  // Contribution of one word: each set bit toggles one bit of every pair.
  function automatic logic [EW-1:0] word_code(input logic [DATA_W-1:0] d,
                                               input logic [WI-1:0] w);
    logic [EW-1:0] c;
    logic [AW-1:0] idx;
    c = '0;
    for (int j = 0; j < DATA_W; j++) begin
      idx = {w, LW'(j)};
      if (d[j]) begin
        for (int k = 0; k < AW; k++) begin
          c[2*k+1] = c[2*k+1] ^ idx[k];
          c[2*k]   = c[2*k]   ^ ~idx[k];
        end
      end
    end
    return c;
  endfunction

  logic [EW-1:0] code_q;
  logic [EW-1:0] contrib;

  assign contrib = en_i ? word_code(data_i, widx_i) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              code_q <= '0;
    else if (clear_i || en_i) code_q <= (clear_i ? '0 : code_q) ^ contrib;
  end

  assign code_o = code_q;
endmodule

// File: rtl/fecc_classify.sv
// Syndrome decoder: clean, single correctable, check-bit only, or fatal.
module fecc_classify
  import fecc_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic [2*AW-1:0] syn_i,
  output ecc_status_e     status_o,
  output logic [AW-1:0]   pos_o,
  output logic            fix_o
);
  logic [AW-1:0] hi;
  logic [AW-1:0] lo;
  logic          split;

  for (genvar g = 0; g < AW; g++) begin : g_pair
    assign hi[g] = syn_i[2*g+1];
    assign lo[g] = syn_i[2*g];
  end

  assign split = &(hi ^ lo);

  always_comb begin
    status_o = ST_CLEAN;
    pos_o    = '0;
    fix_o    = 1'b0;
    if (syn_i != '0) begin
      if (split) begin
        status_o = ST_FIXED;
        pos_o    = hi;
        fix_o    = 1'b1;
      end else if ($countones(syn_i) == 1) begin
        status_o = ST_FIXED;
      end else begin
        status_o = ST_FATAL;
      end
    end
  end
endmodule

// File: rtl/fecc_sector_ram.sv
// Sector store: one write port, one combinational read port.
module fecc_sector_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 264
) (
  input  logic                     clk,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] waddr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [$clog2(DEPTH)-1:0] raddr_i,
  output logic [DATA_W-1:0]        rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/fecc_engine.sv
module fecc_engine
  import fecc_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int MAIN_WORDS  = 256,
  parameter int SPARE_WORDS = 8,
  parameter int SPARE_FIRST = 1,
  parameter int SPARE_COUNT = 2,
  localparam int LW         = $clog2(DATA_W),
  localparam int MAIN_AW    = $clog2(MAIN_WORDS) + LW,
  localparam int SPARE_AW   = $clog2(SPARE_COUNT) + LW,
  localparam int MAIN_EW    = 2 * MAIN_AW,
  localparam int SPARE_EW   = 2 * SPARE_AW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_bypass_i,
  input  logic                op_load_i,
  input  logic                in_valid_i,
  input  logic                in_sop_i,
  input  logic                in_eop_i,
  input  logic [DATA_W-1:0]   in_data_i,
  input  logic [MAIN_EW-1:0]  stored_main_ecc_i,
  input  logic [SPARE_EW-1:0] stored_spare_ecc_i,
  output logic                busy_o,
  output logic                out_valid_o,
  output logic                out_sop_o,
  output logic                out_eop_o,
  output logic [DATA_W-1:0]   out_data_o,
  output logic                ecc_valid_o,
  output logic [MAIN_EW-1:0]  ecc_main_o,
  output logic [SPARE_EW-1:0] ecc_spare_o,
  output logic                result_valid_o,
  output logic [1:0]          main_status_o,
  output logic [MAIN_AW-1:0]  main_pos_o,
  output logic [1:0]          spare_status_o,
  output logic [SPARE_AW-1:0] spare_pos_o
);
  localparam int SECTOR_WORDS = MAIN_WORDS + SPARE_WORDS;
  localparam int IW           = $clog2(SECTOR_WORDS);
  localparam int SPARE_BASE   = MAIN_WORDS + SPARE_FIRST;

  phase_e phase_q;
  logic [IW-1:0] cnt_q, rd_q;

  // Named internal events, used by the bound checker.
  logic                accept, evt_eval, evt_last;
  logic                lat_load, lat_byp;
  logic [MAIN_EW-1:0]  lat_sm;
  logic [SPARE_EW-1:0] lat_ss;

  logic [IW-1:0] wr_idx, spare_rel;
  logic          is_main, is_prot;

  assign accept    = in_valid_i && ((phase_q == PH_IDLE && in_sop_i) || phase_q == PH_RECV);
  assign wr_idx    = in_sop_i ? '0 : cnt_q;
  assign is_main   = wr_idx < IW'(MAIN_WORDS);
  assign spare_rel = wr_idx - IW'(SPARE_BASE);
  assign is_prot   = (wr_idx >= IW'(SPARE_BASE)) && (spare_rel < IW'(SPARE_COUNT));
  assign evt_eval  = (phase_q == PH_EVAL);
  assign evt_last  = (phase_q == PH_SEND) && (rd_q == IW'(SECTOR_WORDS - 1));

  // Check-bit accumulators.
  logic [MAIN_EW-1:0]  code_main;
  logic [SPARE_EW-1:0] code_spare;

  fecc_accum #(.DATA_W(DATA_W), .AW(MAIN_AW)) u_acc_main (
    .clk(clk), .rst_n(rst_n),
    .clear_i(accept && in_sop_i),
    .en_i(accept && is_main && !cfg_bypass_i),
    .widx_i(wr_idx[MAIN_AW-LW-1:0]),
    .data_i(in_data_i),
    .code_o(code_main)
  );

  fecc_accum #(.DATA_W(DATA_W), .AW(SPARE_AW)) u_acc_spare (
    .clk(clk), .rst_n(rst_n),
    .clear_i(accept && in_sop_i),
    .en_i(accept && is_prot && !cfg_bypass_i),
    .widx_i(spare_rel[SPARE_AW-LW-1:0]),
    .data_i(in_data_i),
    .code_o(code_spare)
  );

  // Syndrome classification.
  ecc_status_e         m_st, s_st;
  logic [MAIN_AW-1:0]  m_pos;
  logic [SPARE_AW-1:0] s_pos;
  logic                m_fix, s_fix;

  fecc_classify #(.AW(MAIN_AW)) u_cls_main (
    .syn_i(lat_sm ^ code_main), .status_o(m_st), .pos_o(m_pos), .fix_o(m_fix)
  );

  fecc_classify #(.AW(SPARE_AW)) u_cls_spare (
    .syn_i(lat_ss ^ code_spare), .status_o(s_st), .pos_o(s_pos), .fix_o(s_fix)
  );

  // Sector store.
  logic [DATA_W-1:0] rd_data;

  fecc_sector_ram #(.DATA_W(DATA_W), .DEPTH(SECTOR_WORDS)) u_ram (
    .clk(clk), .we_i(accept), .waddr_i(wr_idx), .wdata_i(in_data_i),
    .raddr_i(rd_q), .rdata_o(rd_data)
  );

  // Correction mask for the word being played back.
  logic              fix_main_q, fix_spare_q;
  logic              main_hit, spare_hit;
  logic [DATA_W-1:0] fix_mask;

  assign main_hit  = fix_main_q && (rd_q == IW'(main_pos_o[MAIN_AW-1:LW]));
  assign spare_hit = fix_spare_q &&
                     (rd_q == IW'(SPARE_BASE) + IW'(spare_pos_o[SPARE_AW-1:LW]));
  assign fix_mask  = (main_hit  ? (DATA_W'(1) << main_pos_o[LW-1:0])  : '0) |
                     (spare_hit ? (DATA_W'(1) << spare_pos_o[LW-1:0]) : '0);

  // Sequencing.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      rd_q     <= '0;
      lat_load <= 1'b0;
      lat_byp  <= 1'b0;
      lat_sm   <= '0;
      lat_ss   <= '0;
    end else begin
      if (accept) cnt_q <= wr_idx + IW'(1);
      unique case (phase_q)
        PH_IDLE: if (accept) phase_q <= in_eop_i ? PH_EVAL : PH_RECV;
        PH_RECV: if (accept && in_eop_i) phase_q <= PH_EVAL;
        PH_EVAL: begin
          phase_q <= PH_SEND;
          rd_q    <= '0;
        end
        PH_SEND: begin
          rd_q <= rd_q + IW'(1);
          if (evt_last) phase_q <= PH_IDLE;
        end
      endcase
      if (accept && in_eop_i) begin
        lat_load <= op_load_i;
        lat_byp  <= cfg_bypass_i;
        lat_sm   <= stored_main_ecc_i;
        lat_ss   <= stored_spare_ecc_i;
      end
    end
  end

  // Result and code outputs.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecc_valid_o    <= 1'b0;
      ecc_main_o     <= '0;
      ecc_spare_o    <= '0;
      result_valid_o <= 1'b0;
      main_status_o  <= ST_CLEAN;
      spare_status_o <= ST_CLEAN;
      main_pos_o     <= '0;
      spare_pos_o    <= '0;
      fix_main_q     <= 1'b0;
      fix_spare_q    <= 1'b0;
    end else begin
      ecc_valid_o    <= 1'b0;
      result_valid_o <= 1'b0;
      if (evt_eval) begin
        fix_main_q  <= 1'b0;
        fix_spare_q <= 1'b0;
        if (lat_load || !lat_byp) begin
          ecc_valid_o <= 1'b1;
          ecc_main_o  <= lat_load ? lat_sm : code_main;
          ecc_spare_o <= lat_load ? lat_ss : code_spare;
        end
        if (lat_load) begin
          result_valid_o <= 1'b1;
          if (lat_byp) begin
            main_status_o  <= ST_INVALID;
            spare_status_o <= ST_INVALID;
            main_pos_o     <= '0;
            spare_pos_o    <= '0;
          end else begin
            main_status_o  <= m_st;
            spare_status_o <= s_st;
            main_pos_o     <= m_pos;
            spare_pos_o    <= s_pos;
            fix_main_q     <= m_fix;
            fix_spare_q    <= s_fix;
          end
        end
      end
    end
  end

  // Playback.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      out_sop_o   <= 1'b0;
      out_eop_o   <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= (phase_q == PH_SEND);
      out_sop_o   <= (phase_q == PH_SEND) && (rd_q == '0);
      out_eop_o   <= evt_last;
      if (phase_q == PH_SEND) out_data_o <= rd_data ^ fix_mask;
    end
  end

  assign busy_o = (phase_q != PH_IDLE) || out_valid_o;
endmodule

// File: rtl/fecc_engine_chk.sv
module fecc_engine_chk
  import fecc_pkg::*;
#(
  parameter int MAIN_EW  = 24,
  parameter int SPARE_EW = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy_o,
  input logic                out_valid_o,
  input logic                out_sop_o,
  input logic                out_eop_o,
  input logic                ecc_valid_o,
  input logic [MAIN_EW-1:0]  ecc_main_o,
  input logic [SPARE_EW-1:0] ecc_spare_o,
  input logic                result_valid_o,
  input logic [1:0]          main_status_o,
  input logic [1:0]          spare_status_o,
  input logic                lat_load,
  input logic                lat_byp,
  input logic [MAIN_EW-1:0]  lat_sm,
  input logic [SPARE_EW-1:0] lat_ss
);
  assert_code_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_valid_o |=> !ecc_valid_o);

  assert_frame_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sop_o || out_eop_o) |-> out_valid_o);

  assert_status_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid_o && !lat_byp) |->
      (main_status_o != ST_INVALID && spare_status_o != ST_INVALID));

  assert_stored_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_valid_o && lat_load) |-> (ecc_main_o == lat_sm && ecc_spare_o == lat_ss));

  assert_no_code_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_valid_o |-> !(lat_byp && !lat_load));

  assert_bypass_invalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid_o && lat_byp) |->
      (main_status_o == ST_INVALID && spare_status_o == ST_INVALID));

  assert_busy_cover_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> busy_o);
endmodule

bind fecc_engine fecc_engine_chk #(.MAIN_EW(MAIN_EW), .SPARE_EW(SPARE_EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .out_valid_o(out_valid_o),
  .out_sop_o(out_sop_o), .out_eop_o(out_eop_o), .ecc_valid_o(ecc_valid_o),
  .ecc_main_o(ecc_main_o), .ecc_spare_o(ecc_spare_o),
  .result_valid_o(result_valid_o), .main_status_o(main_status_o),
  .spare_status_o(spare_status_o), .lat_load(lat_load), .lat_byp(lat_byp),
  .lat_sm(lat_sm), .lat_ss(lat_ss)
);

// File: tb/fecc_engine_test.sv
`timescale 1ns/1ps
module fecc_engine_test;
  localparam int NW = 264;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_bypass_i = 1'b0, op_load_i = 1'b0;
  logic        in_valid_i = 1'b0, in_sop_i = 1'b0, in_eop_i = 1'b0;
  logic [15:0] in_data_i = '0;
  logic [23:0] stored_main_ecc_i = '0;
  logic [9:0]  stored_spare_ecc_i = '0;
  logic        busy_o, out_valid_o, out_sop_o, out_eop_o, ecc_valid_o, result_valid_o;
  logic [15:0] out_data_o;
  logic [23:0] ecc_main_o;
  logic [9:0]  ecc_spare_o;
  logic [1:0]  main_status_o, spare_status_o;
  logic [11:0] main_pos_o;
  logic [4:0]  spare_pos_o;

  fecc_engine uut (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  logic [15:0] clean [NW];
  logic [15:0] tx    [NW];
  logic [15:0] q_data[$];
  logic [33:0] q_ecc [$];
  logic [20:0] q_res [$];
  int out_cnt = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Independent code model: pair k holds parities over index bit k set / clear.
  function automatic logic [23:0] main_code();
    logic [23:0] c = '0;
    for (int k = 0; k < 12; k++)
      for (int b = 0; b < 4096; b++)
        if (clean[b/16][b%16]) begin
          if (b[k]) c[2*k+1] = ~c[2*k+1];
          else      c[2*k]   = ~c[2*k];
        end
    return c;
  endfunction

  function automatic logic [9:0] spare_code();
    logic [9:0] c = '0;
    for (int k = 0; k < 5; k++)
      for (int b = 0; b < 32; b++)
        if (clean[257 + b/16][b%16]) begin
          if (b[k]) c[2*k+1] = ~c[2*k+1];
          else      c[2*k]   = ~c[2*k];
        end
    return c;
  endfunction

  // Driver: pushes the expected items, then streams the sector.
  task automatic run(input bit ld, input bit byp, input logic [23:0] sm,
                     input logic [9:0] ss, input bit want_ecc,
                     input logic [33:0] eccv, input bit want_res,
                     input logic [20:0] resv, input bit use_clean);
    for (int i = 0; i < NW; i++) q_data.push_back(use_clean ? clean[i] : tx[i]);
    if (want_ecc) q_ecc.push_back(eccv);
    if (want_res) q_res.push_back(resv);
    for (int i = 0; i < NW; i++) begin
      @(negedge clk);
      in_valid_i = 1'b1; in_sop_i = (i == 0); in_eop_i = (i == NW-1);
      in_data_i = tx[i]; op_load_i = ld; cfg_bypass_i = byp;
      stored_main_ecc_i = sm; stored_spare_ecc_i = ss;
    end
    @(negedge clk);
    in_valid_i = 1'b0; in_sop_i = 1'b0; in_eop_i = 1'b0;
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid_o) begin
        if (q_data.size() == 0) chk(0, "R2", "unexpected word", out_data_o, 0);
        else begin
          logic [15:0] e;
          e = q_data.pop_front();
          chk(out_data_o == e, "R2/R4", $sformatf("word %0d", out_cnt), out_data_o, e);
          chk(out_sop_o == (out_cnt == 0) && out_eop_o == (out_cnt == NW-1), "R2",
              "frame flags", {out_sop_o, out_eop_o}, {out_cnt == 0, out_cnt == NW-1});
        end
        out_cnt = (out_cnt == NW-1) ? 0 : out_cnt + 1;
      end
      if (ecc_valid_o) begin
        if (q_ecc.size() == 0) chk(0, "R9", "unexpected code pulse", ecc_main_o, 0);
        else begin
          logic [33:0] e;
          e = q_ecc.pop_front();
          chk({ecc_main_o, ecc_spare_o} == e, "R1/R8", "code outputs",
              {ecc_main_o, ecc_spare_o}, e);
        end
      end
      if (result_valid_o) begin
        if (q_res.size() == 0) chk(0, "R3", "unexpected result", main_status_o, 0);
        else begin
          logic [20:0] e;
          e = q_res.pop_front();
          chk({main_status_o, main_pos_o, spare_status_o, spare_pos_o} == e,
              "R3-R7/R10", "status/pos",
              {main_status_o, main_pos_o, spare_status_o, spare_pos_o}, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [20:0] res(input logic [1:0] ms, input logic [11:0] mp,
                                      input logic [1:0] ss, input logic [4:0] sp);
    return {ms, mp, ss, sp};
  endfunction

  task automatic reload();
    for (int i = 0; i < NW; i++) tx[i] = clean[i];
  endtask

  initial begin
    logic [23:0] mc;
    logic [9:0]  sc;
    logic [31:0] lfsr;
    lfsr = 32'h1234_5678;
    for (int i = 0; i < NW; i++) begin
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      clean[i] = lfsr[31:16];
    end
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(!busy_o && !out_valid_o && !ecc_valid_o, "R11", "reset outputs",
        {busy_o, out_valid_o, ecc_valid_o}, 0);
    chk(main_status_o == 2'b00 && spare_status_o == 2'b00, "R11", "reset status",
        {main_status_o, spare_status_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    mc = main_code(); sc = spare_code();

    // R1: program, computed codes
    reload(); run(0, 0, '0, '0, 1, {mc, sc}, 0, '0, 0);
    // R3/R8: clean load
    reload(); run(1, 0, mc, sc, 1, {mc, sc}, 1, res(2'b00, 0, 2'b00, 0), 0);
    // R4: single main flips, middle and both ends
    reload(); tx[77][2] = ~tx[77][2];
    run(1, 0, mc, sc, 1, {mc, sc}, 1, res(2'b01, 12'd1234, 2'b00, 0), 1);
    reload(); tx[0][0] = ~tx[0][0];
    run(1, 0, mc, sc, 1, {mc, sc}, 1, res(2'b01, 12'd0, 2'b00, 0), 1);
    reload(); tx[255][15] = ~tx[255][15];
    run(1, 0, mc, sc, 1, {mc, sc}, 1, res(2'b01, 12'd4095, 2'b00, 0), 1);
    // R5: check-bit error
    reload(); run(1, 0, mc ^ 24'h000020, sc, 1, {mc ^ 24'h000020, sc}, 1,
                  res(2'b01, 0, 2'b00, 0), 1);
    // R6: double main error
    reload(); tx[6][4] = ~tx[6][4]; tx[187][8] = ~tx[187][8];
    run(1, 0, mc, sc, 1, {mc, sc}, 1, res(2'b10, 0, 2'b00, 0), 0);
    // R7: spare single in protected word 258 bit 7
    reload(); tx[258][7] = ~tx[258][7];
    run(1, 0, mc, sc, 1, {mc, sc}, 1, res(2'b00, 0, 2'b01, 5'd23), 1);
    // R7: flip in unprotected spare word 261
    reload(); tx[261][3] = ~tx[261][3];
    run(1, 0, mc, sc, 1, {mc, sc}, 1, res(2'b00, 0, 2'b00, 0), 0);
    // R7: spare double
    reload(); tx[257][1] = ~tx[257][1]; tx[258][9] = ~tx[258][9];
    run(1, 0, mc, sc, 1, {mc, sc}, 1, res(2'b00, 0, 2'b10, 0), 0);
    // R9: bypass program, no code pulse expected
    reload(); run(0, 1, '0, '0, 0, '0, 0, '0, 0);
    // R10: bypass load with a flip, not corrected, stored codes returned
    reload(); tx[40][11] = ~tx[40][11];
    run(1, 1, 24'hABCDEF, 10'h155, 1, {24'hABCDEF, 10'h155}, 1,
        res(2'b11, 0, 2'b11, 0), 0);
    // R1: all-zero sector gives zero code
    for (int i = 0; i < NW; i++) clean[i] = '0;
    reload(); run(0, 0, '0, '0, 1, {24'h0, 10'h0}, 0, '0, 0);

    chk(q_data.size() == 0 && q_ecc.size() == 0 && q_res.size() == 0, "R2/R9",
        "scoreboard drained", q_data.size() + q_ecc.size() + q_res.size(), 0);
    chk(!busy_o, "R11", "idle at end", busy_o, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule